// File: doc/BRIEF.md
# Interrupt Source Pending Tracker

This block sits between raw interrupt request lines and a priority arbiter. It keeps one pending bit and one stored level bit for every (source, CPU) pair. Every request line first passes through a two-flop synchronizer. A change detector then compares the synchronized line with the stored level for that source. A rising change can mark the source pending for the CPUs it targets. Whether it does depends on the source's trigger type (edge or level) and on its enable bit. The enable bits are held in this block.

Source IDs below 32 are private. Each CPU has its own line for each of these IDs, and such an ID only ever targets its own CPU. IDs from 32 upward are shared. One line feeds all CPUs, and a per-source CPU mask selects the CPUs it targets. Level-sensitive sources are re-armed in two cases: when they are enabled while their line is high, and when an end-of-interrupt event finds them still asserted. The acknowledge logic removes pending bits through a clear port. The arbiter reads the flat pending vector.

Top module: `irq_pend_tracker`

## Requirements
- R1: Each request line passes through two synchronizer flops and then the stored-level register. A line driven before rising edge N is visible on `level_o` after edge N+2, and not after edge N+1.
- R2: A rising change on an edge-triggered source (`trig_edge_i[id]`=1) sets the stored level and marks the source pending for every targeted CPU, even when the source is disabled.
- R3: A rising change on a level-triggered source (`trig_edge_i[id]`=0) marks it pending for its targeted CPUs only if it is enabled for that CPU. If it is disabled, only the stored level is set.
- R4: A falling change clears only the stored level. Pending bits are left unchanged.
- R5: A line that stays at the same level causes no further action. After its pending bit is cleared, an edge-triggered source whose line is still high stays not pending.
- R6: An enable write with `en_val_i`=1 to a level-triggered source whose stored level is high marks it pending for its targeted CPUs at the same edge that sets the enable.
- R7: An end-of-interrupt on (`eoi_id_i`, `eoi_cpu_i`) marks that slot pending again at the next edge, but only when the source is level-triggered, enabled, has a high stored level and targets that CPU. Otherwise it has no effect.
- R8: All vectors use flat slot index id*NUM_CPU+cpu. IDs 0..31 take line `priv_irq_i[cpu*32+id]` and target only their own CPU. IDs from 32 upward take `shared_irq_i[id-32]` and target CPU c when `target_i[(id-32)*NUM_CPU+c]` is 1. Enable writes to a shared ID apply to all CPUs. Writes to a private ID apply only to `en_cpu_i`.
- R9: IDs 0..15 are enabled out of reset and stay enabled. An enable write with `en_val_i`=0 to them has no effect.
- R10: After reset no slot is pending, no level is stored, and IDs from 16 upward are disabled. An acknowledge clear on (`ack_id_i`, `ack_cpu_i`) clears that slot at the next edge. Nothing else clears a pending bit.
- R11: If a clear and a set hit the same slot at the same edge, the slot ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shared_irq_i | input | NUM_SRC-32 | Shared request lines, bit i is ID 32+i |
| priv_irq_i | input | NUM_CPU*32 | Private request lines, bit cpu*32+id |
| trig_edge_i | input | NUM_SRC | Trigger type per ID: 1 edge, 0 level |
| target_i | input | (NUM_SRC-32)*NUM_CPU | CPU mask per shared ID |
| en_wr_i | input | 1 | Enable write strobe |
| en_val_i | input | 1 | 1 enables, 0 disables |
| en_id_i | input | $clog2(NUM_SRC) | ID written |
| en_cpu_i | input | max(1,$clog2(NUM_CPU)) | CPU for private-ID writes |
| ack_clr_i | input | 1 | Acknowledge clear strobe |
| ack_id_i | input | $clog2(NUM_SRC) | ID to clear |
| ack_cpu_i | input | max(1,$clog2(NUM_CPU)) | CPU to clear |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | $clog2(NUM_SRC) | Completed ID |
| eoi_cpu_i | input | max(1,$clog2(NUM_CPU)) | Completing CPU |
| pend_o | output | NUM_SRC*NUM_CPU | Pending bit per slot |
| level_o | output | NUM_SRC*NUM_CPU | Stored level per slot |
| en_o | output | NUM_SRC*NUM_CPU | Enable bit per slot |

## Verification
A line change shows on `level_o` and `pend_o` after the third rising edge following the drive. Enable writes, acknowledge clears and end-of-interrupt events take effect after the first edge. The bench drives every stimulus on a falling edge, counts the exact number of rising edges, and samples on the next falling edge. For R1 it also samples one edge early, where the line must still be invisible. For the no-effect cases (a disable write to a locked ID, an end-of-interrupt with conditions unmet, a line held steady) the bench reads `en_o` or `pend_o` after the due cycle and before the next stimulus.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned PRIV_IDS   = 32;
  localparam int unsigned LOCKED_IDS = 16;
endpackage

// File: rtl/irq_sync_2ff.sv
module irq_sync_2ff #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned NUM_CPU = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_i,
  input  logic                                val_i,
  input  logic [$clog2(NUM_SRC)-1:0]          id_i,
  input  logic [(NUM_CPU>1?$clog2(NUM_CPU):1)-1:0] cpu_i,
  output logic [NUM_SRC*NUM_CPU-1:0]          en_o,
  output logic [NUM_SRC*NUM_CPU-1:0]          set_o
);
  localparam int unsigned ID_W  = $clog2(NUM_SRC);
  localparam int unsigned CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      localparam int unsigned K      = s * NUM_CPU + c;
      localparam logic        LOCKED = (s < LOCKED_IDS);
      logic hit, en_q;

      if (s < PRIV_IDS) begin : g_priv
        assign hit = wr_i && (id_i == ID_W'(s)) && (cpu_i == CPU_W'(c));
      end else begin : g_shr
        assign hit = wr_i && (id_i == ID_W'(s));
      end

      // locked IDs ignore disable writes
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  en_q <= LOCKED;
        else if (hit) en_q <= val_i | LOCKED;
      end

      assign en_o[K]  = en_q;
      assign set_o[K] = hit & val_i;
    end
  end
endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core #(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned NUM_CPU = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_SRC*NUM_CPU-1:0]          lvl_in_i,
  input  logic [NUM_SRC*NUM_CPU-1:0]          tgt_i,
  input  logic [NUM_SRC*NUM_CPU-1:0]          en_i,
  input  logic [NUM_SRC*NUM_CPU-1:0]          en_set_i,
  input  logic [NUM_SRC-1:0]                  edge_i,
  input  logic                                clr_i,
  input  logic [$clog2(NUM_SRC)-1:0]          clr_id_i,
  input  logic [(NUM_CPU>1?$clog2(NUM_CPU):1)-1:0] clr_cpu_i,
  input  logic                                eoi_i,
  input  logic [$clog2(NUM_SRC)-1:0]          eoi_id_i,
  input  logic [(NUM_CPU>1?$clog2(NUM_CPU):1)-1:0] eoi_cpu_i,
  output logic [NUM_SRC*NUM_CPU-1:0]          pend_o,
  output logic [NUM_SRC*NUM_CPU-1:0]          lvl_o
);
  localparam int unsigned ID_W  = $clog2(NUM_SRC);
  localparam int unsigned CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam int unsigned SLOTS = NUM_SRC * NUM_CPU;

  logic [SLOTS-1:0] lvl_q, pend_q, set_v, clr_v;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      localparam int unsigned K = s * NUM_CPU + c;
      logic rise, eoi_hit, lvl_rearm;

      assign rise      = lvl_in_i[K] & ~lvl_q[K];
      assign eoi_hit   = eoi_i && (eoi_id_i == ID_W'(s)) && (eoi_cpu_i == CPU_W'(c));
      // level sources re-arm on enable or completion while still high
      assign lvl_rearm = ~edge_i[s] & lvl_q[K] & (en_set_i[K] | (eoi_hit & en_i[K]));
      assign set_v[K]  = tgt_i[K] & ((rise & (edge_i[s] | en_i[K])) | lvl_rearm);
      assign clr_v[K]  = clr_i && (clr_id_i == ID_W'(s)) && (clr_cpu_i == CPU_W'(c));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      pend_q <= '0;
    end else begin
      lvl_q  <= lvl_in_i;
      pend_q <= (pend_q & ~clr_v) | set_v;  // set wins
    end
  end

  assign pend_o = pend_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned NUM_CPU = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_SRC-32-1:0]               shared_irq_i,
  input  logic [NUM_CPU*32-1:0]               priv_irq_i,
  input  logic [NUM_SRC-1:0]                  trig_edge_i,
  input  logic [(NUM_SRC-32)*NUM_CPU-1:0]     target_i,
  input  logic                                en_wr_i,
  input  logic                                en_val_i,
  input  logic [$clog2(NUM_SRC)-1:0]          en_id_i,
  input  logic [(NUM_CPU>1?$clog2(NUM_CPU):1)-1:0] en_cpu_i,
  input  logic                                ack_clr_i,
  input  logic [$clog2(NUM_SRC)-1:0]          ack_id_i,
  input  logic [(NUM_CPU>1?$clog2(NUM_CPU):1)-1:0] ack_cpu_i,
  input  logic                                eoi_i,
  input  logic [$clog2(NUM_SRC)-1:0]          eoi_id_i,
  input  logic [(NUM_CPU>1?$clog2(NUM_CPU):1)-1:0] eoi_cpu_i,
  output logic [NUM_SRC*NUM_CPU-1:0]          pend_o,
  output logic [NUM_SRC*NUM_CPU-1:0]          level_o,
  output logic [NUM_SRC*NUM_CPU-1:0]          en_o
);
  localparam int unsigned NUM_SHR = NUM_SRC - PRIV_IDS;
  localparam int unsigned LINES   = NUM_SHR + NUM_CPU * PRIV_IDS;
  localparam int unsigned SLOTS   = NUM_SRC * NUM_CPU;

  logic [LINES-1:0] raw_lines, syn_lines;
  logic [SLOTS-1:0] slot_lvl, slot_tgt, en_set;

  assign raw_lines = {priv_irq_i, shared_irq_i};

  irq_sync_2ff #(.W(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_lines),
    .q_o   (syn_lines)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      localparam int unsigned K = s * NUM_CPU + c;
      if (s < PRIV_IDS) begin : g_priv
        assign slot_lvl[K] = syn_lines[NUM_SHR + c * PRIV_IDS + s];
        assign slot_tgt[K] = 1'b1;
      end else begin : g_shr
        assign slot_lvl[K] = syn_lines[s - PRIV_IDS];
        assign slot_tgt[K] = target_i[(s - PRIV_IDS) * NUM_CPU + c];
      end
    end
  end

  irq_enable_bank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (en_wr_i),
    .val_i (en_val_i),
    .id_i  (en_id_i),
    .cpu_i (en_cpu_i),
    .en_o  (en_o),
    .set_o (en_set)
  );

  irq_pend_core #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_in_i (slot_lvl),
    .tgt_i    (slot_tgt),
    .en_i     (en_o),
    .en_set_i (en_set),
    .edge_i   (trig_edge_i),
    .clr_i    (ack_clr_i),
    .clr_id_i (ack_id_i),
    .clr_cpu_i(ack_cpu_i),
    .eoi_i    (eoi_i),
    .eoi_id_i (eoi_id_i),
    .eoi_cpu_i(eoi_cpu_i),
    .pend_o   (pend_o),
    .lvl_o    (level_o)
  );
endmodule

// File: rtl/irq_pend_tracker_chk.sv
module irq_pend_tracker_chk
  import irq_pend_pkg::*;
#(
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned NUM_CPU = 2
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic [NUM_SRC-32-1:0]               shared_irq_i,
  input logic [NUM_CPU*32-1:0]               priv_irq_i,
  input logic [NUM_SRC-1:0]                  trig_edge_i,
  input logic [(NUM_SRC-32)*NUM_CPU-1:0]     target_i,
  input logic                                en_wr_i,
  input logic                                en_val_i,
  input logic [$clog2(NUM_SRC)-1:0]          en_id_i,
  input logic [(NUM_CPU>1?$clog2(NUM_CPU):1)-1:0] en_cpu_i,
  input logic                                ack_clr_i,
  input logic [$clog2(NUM_SRC)-1:0]          ack_id_i,
  input logic [(NUM_CPU>1?$clog2(NUM_CPU):1)-1:0] ack_cpu_i,
  input logic                                eoi_i,
  input logic [$clog2(NUM_SRC)-1:0]          eoi_id_i,
  input logic [(NUM_CPU>1?$clog2(NUM_CPU):1)-1:0] eoi_cpu_i,
  input logic [NUM_SRC*NUM_CPU-1:0]          pend_o,
  input logic [NUM_SRC*NUM_CPU-1:0]          level_o,
  input logic [NUM_SRC*NUM_CPU-1:0]          en_o
);
  localparam int unsigned SLOTS = NUM_SRC * NUM_CPU;

  logic [SLOTS-1:0] tgt, lvl_prev_q;
  int unsigned clr_idx, eoi_idx, clr_idx_q, eoi_idx_q;
  logic clr_hit_q, eoi_exp, eoi_exp_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_t
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
      if (s < PRIV_IDS) begin : g_p
        assign tgt[s*NUM_CPU+c] = 1'b1;
      end else begin : g_s
        assign tgt[s*NUM_CPU+c] = target_i[(s-PRIV_IDS)*NUM_CPU+c];
      end
    end
  end

  assign clr_idx = int'(ack_id_i) * NUM_CPU + int'(ack_cpu_i);
  assign eoi_idx = int'(eoi_id_i) * NUM_CPU + int'(eoi_cpu_i);
  assign eoi_exp = eoi_i && (eoi_idx < SLOTS) && !trig_edge_i[eoi_id_i]
                   && en_o[eoi_idx] && level_o[eoi_idx] && tgt[eoi_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_idx_q  <= 0;
      eoi_idx_q  <= 0;
      clr_hit_q  <= 1'b0;
      eoi_exp_q  <= 1'b0;
      lvl_prev_q <= '0;
    end else begin
      clr_idx_q  <= clr_idx;
      eoi_idx_q  <= eoi_idx;
      clr_hit_q  <= ack_clr_i && !eoi_i && !en_wr_i && (clr_idx < SLOTS);
      eoi_exp_q  <= eoi_exp;
      lvl_prev_q <= level_o;
    end
  end

  // R2: an edge-triggered source whose stored level rises is pending where targeted
  for (genvar k = 0; k < SLOTS; k++) begin : g_rise
    p_rise_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(level_o[k]) && $past(trig_edge_i[k/NUM_CPU]) && $past(tgt[k])) |-> pend_o[k]);
  end

  // R9: locked IDs never read as disabled
  for (genvar k = 0; k < LOCKED_IDS * NUM_CPU; k++) begin : g_lock
    p_locked_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni) en_o[k]);
  end

  // R10: a pending bit drops only after a clear request
  p_drop_on_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pend_o) & ~pend_o)) |-> $past(ack_clr_i));

  // R10: a lone clear takes effect unless the line rose in the same cycle
  p_clr_effect_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit_q && !(level_o[clr_idx_q] && !lvl_prev_q[clr_idx_q])) |-> !pend_o[clr_idx_q]);

  // R7: completion of a still-high enabled level source re-arms it
  p_eoi_rearm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_exp_q |-> pend_o[eoi_idx_q]);
endmodule

bind irq_pend_tracker irq_pend_tracker_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (.*);

// File: tb/irq_pend_tracker_tb_top.sv
module irq_pend_tracker_tb_top;
  localparam int unsigned NS = 40;
  localparam int unsigned NC = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NS-32-1:0]      shared_irq_i = '0;
  logic [NC*32-1:0]      priv_irq_i = '0;
  logic [NS-1:0]         trig_edge_i = '0;
  logic [(NS-32)*NC-1:0] target_i = '0;
  logic       en_wr_i = 1'b0, en_val_i = 1'b0;
  logic [5:0] en_id_i = '0;
  logic [0:0] en_cpu_i = '0;
  logic       ack_clr_i = 1'b0;
  logic [5:0] ack_id_i = '0;
  logic [0:0] ack_cpu_i = '0;
  logic       eoi_i = 1'b0;
  logic [5:0] eoi_id_i = '0;
  logic [0:0] eoi_cpu_i = '0;
  logic [NS*NC-1:0] pend_o, level_o, en_o;

  int vec_cnt = 0;
  int err_cnt = 0;

  always #4 clk_i = ~clk_i;

  irq_pend_tracker #(.NUM_SRC(NS), .NUM_CPU(NC)) dut_i (.*);

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic en_write(input int id, input int cpu, input logic v);
    en_wr_i = 1'b1; en_val_i = v; en_id_i = 6'(id); en_cpu_i = 1'(cpu);
    step(1);
    en_wr_i = 1'b0;
  endtask

  task automatic ack(input int id, input int cpu);
    ack_clr_i = 1'b1; ack_id_i = 6'(id); ack_cpu_i = 1'(cpu);
    step(1);
    ack_clr_i = 1'b0;
  endtask

  task automatic eoi(input int id, input int cpu);
    eoi_i = 1'b1; eoi_id_i = 6'(id); eoi_cpu_i = 1'(cpu);
    step(1);
    eoi_i = 1'b0;
  endtask

  task automatic t_reset_r10();
    chk("R10", "no pending after reset", |pend_o, 1'b0);
    chk("R10", "no level after reset", |level_o, 1'b0);
    chk("R9", "locked ids enabled at reset", &en_o[31:0], 1'b1);
    chk("R10", "ids >= 16 disabled at reset", |en_o[NS*NC-1:32], 1'b0);
  endtask

  task automatic t_sync_r1();
    priv_irq_i[20] = 1'b1;            // id 20, cpu 0, slot 40
    step(2);
    chk("R1", "level hidden after 2 edges", level_o[40], 1'b0);
    step(1);
    chk("R1", "level visible after 3 edges", level_o[40], 1'b1);
    chk("R3", "disabled level source not pending", pend_o[40], 1'b0);
  endtask

  task automatic t_enable_r6();
    en_write(20, 0, 1'b1);
    chk("R6", "enable of high level source pends", pend_o[40], 1'b1);
    chk("R8", "private enable only own cpu", en_o[41], 1'b0);
    chk("R8", "other cpu slot not pending", pend_o[41], 1'b0);
  endtask

  task automatic t_fall_r4();
    priv_irq_i[20] = 1'b0;
    step(3);
    chk("R4", "level cleared on fall", level_o[40], 1'b0);
    chk("R4", "pending kept on fall", pend_o[40], 1'b1);
  endtask

  task automatic t_clear_r10();
    ack(20, 0);
    chk("R10", "clear removes pending", pend_o[40], 1'b0);
  endtask

  task automatic t_edge_r2();
    shared_irq_i[1] = 1'b1;           // id 33, slots 66/67
    step(3);
    chk("R2", "shared level stored cpu0", level_o[66], 1'b1);
    chk("R2", "edge source pends while disabled", pend_o[67], 1'b1);
    chk("R8", "untargeted cpu not pending", pend_o[66], 1'b0);
  endtask

  task automatic t_repeat_r5();
    ack(33, 1);
    chk("R10", "edge source cleared", pend_o[67], 1'b0);
    step(4);
    chk("R5", "held line does not re-pend", pend_o[67], 1'b0);
  endtask

  task automatic t_shared_level_r3();
    en_write(34, 0, 1'b1);
    chk("R8", "shared enable cpu0", en_o[68], 1'b1);
    chk("R8", "shared enable cpu1", en_o[69], 1'b1);
    shared_irq_i[2] = 1'b1;
    step(3);
    chk("R3", "enabled level source pends cpu0", pend_o[68], 1'b1);
    chk("R3", "enabled level source pends cpu1", pend_o[69], 1'b1);
  endtask

  task automatic t_eoi_r7();
    ack(34, 0);
    chk("R10", "ack clears cpu0 slot", pend_o[68], 1'b0);
    eoi(34, 0);
    chk("R7", "eoi re-arms high level source", pend_o[68], 1'b1);
    eoi(33, 1);
    chk("R7", "eoi ignores edge source", pend_o[67], 1'b0);
    shared_irq_i[2] = 1'b0;
    step(3);
    ack(34, 1);
    eoi(34, 1);
    chk("R7", "eoi ignores low level source", pend_o[69], 1'b0);
  endtask

  task automatic t_locked_r9();
    en_write(5, 1, 1'b0);
    chk("R9", "disable write to locked id ignored", en_o[11], 1'b1);
    priv_irq_i[32+5] = 1'b1;          // id 5, cpu 1, slot 11
    step(3);
    chk("R9", "locked level source pends", pend_o[11], 1'b1);
  endtask

  task automatic t_collide_r11();
    ack_clr_i = 1'b1; ack_id_i = 6'd5; ack_cpu_i = 1'b1;
    eoi_i = 1'b1; eoi_id_i = 6'd5; eoi_cpu_i = 1'b1;
    step(1);
    eoi_i = 1'b0;
    chk("R11", "set wins over clear", pend_o[11], 1'b1);
    step(1);
    ack_clr_i = 1'b0;
    chk("R10", "lone clear after collision", pend_o[11], 1'b0);
  endtask

  initial begin
    trig_edge_i[33] = 1'b1;
    target_i[3] = 1'b1;               // id 33 -> cpu1
    target_i[4] = 1'b1;               // id 34 -> cpu0
    target_i[5] = 1'b1;               // id 34 -> cpu1
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_r10();
    t_sync_r1();
    t_enable_r6();
    t_fall_r4();
    t_clear_r10();
    t_edge_r2();
    t_repeat_r5();
    t_shared_level_r3();
    t_eoi_r7();
    t_locked_r9();
    t_collide_r11();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule